// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Slice

This block is one tap of a fixed-point filter. Each accepted sample goes through three registers: an input register, a product register and an accumulator/output register. A per-sample mode bit picks one of two ways to use the same datapath. In dual mode there are two signed multipliers, 19 x 18 bits each, and their products are added or subtracted. In wide mode there is one signed 27 x 27 multiplier. Several options act on the first operand lanes:

- A pre-adder sums two 18-bit data inputs before the multiply, for symmetric taps.
- An eight-entry internal coefficient bank can stand in for the external coefficient operand.
- A cascade path can take the first data operand from the neighbouring slice. The registered operand is then passed on to the next slice, which forms a tap-delay line.

The output stage forms a 64-bit value. It starts from a base, which is either the running accumulator or zero. It then adds or subtracts the product sum and adds a 64-bit chain input from the previous slice. The unrounded sum goes out on the chain output to the next slice. An optional biased rounding step is applied only to the result port.

Top module: `mac_slice`

## Requirements
- R1: With `mode`=0 (dual), the product sum is P0 + P1, or P0 - P1 when `prod_sub`=1. P1 is the signed `c_in[18:0]` times the signed `d_in[17:0]`. Without the pre-adder, P0 is the signed `a[18:0]` times the signed coefficient bits `[17:0]`.
- R2: With `mode`=1 (wide), the product sum is the signed `a[26:0]` times the signed coefficient `[26:0]`. `prod_sub`, `c_in` and `d_in` have no effect.
- R3: With `preadd_en`=1, the data operand of the first multiplier is the signed sum of `a[17:0]` and `y_in[17:0]`. Each addend is 18 bits and the sum is 19 bits. This holds in both modes.
- R4: The operand `a` is `cascade_in` when `casc_sel`=1 and `a_in` otherwise. `cascade_out` is the `a` value of the last accepted sample, zero-extended from its low 18 bits if the pre-adder was on. Otherwise it is zero-extended from the low 19 bits in dual mode and carries all 27 bits in wide mode.
- R5: A write with `coef_we`=1 stores `coef_wdata` at `coef_waddr` on that clock edge. With `coef_use`=1, a sample takes its coefficient from entry `coef_idx` instead of `b_in`. The read sees the contents from before a write at the same edge. All entries are zero after reset.
- R6: For each sample, the new 64-bit value is base + T + `chain_in`. T is the product sum, or its negation when `acc_sub`=1. The base is the previous accumulator when `acc_en`=1 and zero when `acc_en`=0. `chain_out` shows the new value.
- R7: `acc_clr`=1 makes the base zero for that sample, whatever the old accumulator contents.
- R8: `chain_in` is added into every sample's new value, modulo 2^64.
- R9: With `round_en`=1 and a nonzero `round_pos`=k, `result` is (V + 2^(k-1)) with bits below k cleared, modulo 2^64, where V is the new value. Otherwise `result` equals V. The accumulator and `chain_out` are never rounded.
- R10: A sample accepted at clock edge n, with `in_valid`=1, gives `out_valid`=1 together with its `result` and `chain_out` after edge n+2. When no sample arrives, `out_valid` is 0 and `result` and `chain_out` hold their values.
- R11: After a synchronous reset, `out_valid`, `result`, `chain_out` and `cascade_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accepted on this edge |
| mode | input | 1 | 0 dual 19x18, 1 single 27x27 |
| preadd_en | input | 1 | Use pre-adder a+y for first data operand |
| prod_sub | input | 1 | Dual mode: subtract second product |
| acc_en | input | 1 | Add onto previous accumulator |
| acc_sub | input | 1 | Subtract product sum instead of adding |
| acc_clr | input | 1 | Ignore old accumulator for this sample |
| round_en | input | 1 | Apply biased rounding to result |
| round_pos | input | 6 | Rounding bit position k |
| casc_sel | input | 1 | Take first data operand from cascade_in |
| coef_use | input | 1 | Take coefficient from internal bank |
| coef_idx | input | 3 | Bank entry to read |
| coef_we | input | 1 | Bank write strobe |
| coef_waddr | input | 3 | Bank write entry |
| coef_wdata | input | 27 | Bank write value |
| a_in | input | 27 | First data operand |
| y_in | input | 18 | Pre-adder second addend |
| b_in | input | 27 | External coefficient |
| c_in | input | 19 | Second multiplier data operand |
| d_in | input | 18 | Second multiplier coefficient |
| cascade_in | input | 27 | Operand from previous slice |
| chain_in | input | 64 | Partial sum from previous slice |
| cascade_out | output | 27 | Registered operand to next slice |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Rounded result |
| chain_out | output | 64 | Unrounded sum to next slice |

## Verification
On every cycle, the assertions check four things: the three-cycle valid latency, the magnitude bounds of the registered product sum in each mode, the cleared low bits of a rounded result, and the value the output stage forms after a clear. The bench's scenarios are the only place that shows the arithmetic. They cover operand field selection, pre-adder and cascade widths, coefficient bank contents and read-before-write timing, add and subtract accumulation across gaps, the chain input, and rounding at positions 0, 1 and 63. All of these are compared against an integer model of the requirements.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int DATA_W  = 27;
    localparam int NA_W    = 19;
    localparam int NB_W    = 18;
    localparam int PRE_W   = 18;
    localparam int ACC_W   = 64;
    localparam int COEF_N  = 8;
    localparam int COEF_AW = $clog2(COEF_N);
    localparam int RPOS_W  = $clog2(ACC_W);

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_WIDE = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  preadd;
        logic  sub;
    } mul_ctl_t;

    typedef struct packed {
        logic              acc_en;
        logic              acc_sub;
        logic              acc_clr;
        logic              round_en;
        logic [RPOS_W-1:0] round_pos;
    } acc_ctl_t;

    // sign-extend the low w bits of v to the accumulator width
    function automatic logic signed [ACC_W-1:0] sext(input logic [DATA_W-1:0] v, input int w);
        logic signed [ACC_W-1:0] t;
        t = $signed({{(ACC_W-DATA_W){1'b0}}, v});
        t = t <<< (ACC_W - w);
        return t >>> (ACC_W - w);
    endfunction

    // width of the operand handed to the next slice
    function automatic logic [DATA_W-1:0] casc_mask(input mode_e m, input logic pre);
        int w;
        if (pre)                 w = PRE_W;
        else if (m == MODE_DUAL) w = NA_W;
        else                     w = DATA_W;
        return {DATA_W{1'b1}} >> (DATA_W - w);
    endfunction

    // biased rounding: add half an LSB at position k, then clear below k
    function automatic logic [ACC_W-1:0] round_val(input logic [ACC_W-1:0] v, input logic en,
                                                   input logic [RPOS_W-1:0] k);
        logic [ACC_W-1:0] half;
        logic [ACC_W-1:0] keep;
        if (!en || k == '0) return v;
        half = ACC_W'(1) << (k - RPOS_W'(1));
        keep = ~((ACC_W'(1) << k) - ACC_W'(1));
        return (v + half) & keep;
    endfunction
endpackage

// File: rtl/mac_coef_bank.sv
module mac_coef_bank
    import mac_pkg::*;
#(
    parameter int DEPTH = COEF_N,
    parameter int W     = DATA_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[i] <= '0;
            else if (we && waddr == AW'(i))
                entry[i] <= wdata;
        end
    end

    assign rdata = entry[raddr];
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              v_in,
    input  mul_ctl_t          mc,
    input  acc_ctl_t          ac_in,
    input  logic [DATA_W-1:0] a,
    input  logic [PRE_W-1:0]  y,
    input  logic [DATA_W-1:0] b,
    input  logic [NA_W-1:0]   c,
    input  logic [NB_W-1:0]   d,
    output logic              v_out,
    output logic [ACC_W-1:0]  sum_out,
    output acc_ctl_t          ac_out
);
    logic signed [ACC_W-1:0] pre_sum, p0, p1, pw, sum_c;
    mode_e mode_q;

    always_comb begin
        pre_sum = sext({{(DATA_W-PRE_W){1'b0}}, a[PRE_W-1:0]}, PRE_W)
                + sext({{(DATA_W-PRE_W){1'b0}}, y}, PRE_W);
        p0 = (mc.preadd ? pre_sum : sext(a, NA_W)) * sext(b, NB_W);
        p1 = sext({{(DATA_W-NA_W){1'b0}}, c}, NA_W) * sext({{(DATA_W-NB_W){1'b0}}, d}, NB_W);
        pw = (mc.preadd ? pre_sum : sext(a, DATA_W)) * sext(b, DATA_W);
        if (mc.mode == MODE_WIDE) sum_c = pw;
        else if (mc.sub)          sum_c = p0 - p1;
        else                      sum_c = p0 + p1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out   <= 1'b0;
            sum_out <= '0;
            ac_out  <= '0;
            mode_q  <= MODE_DUAL;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                sum_out <= sum_c;
                ac_out  <= ac_in;
                mode_q  <= mc.mode;
            end
        end
    end

    // R1: two 19x18 products never exceed 2^36 in magnitude
    a_r1_dual_range: assert property (@(posedge clk) disable iff (rst)
        (v_out && mode_q == MODE_DUAL) |->
        ($signed(sum_out) <= 64'sd68719476736 && $signed(sum_out) >= -64'sd68719476736));

    // R2: one 27x27 product never exceeds 2^52 in magnitude
    a_r2_wide_range: assert property (@(posedge clk) disable iff (rst)
        (v_out && mode_q == MODE_WIDE) |->
        ($signed(sum_out) <= 64'sd4503599627370496 && $signed(sum_out) >= -64'sd4503599627370496));
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             v_in,
    input  logic [ACC_W-1:0] sum_in,
    input  acc_ctl_t         ac,
    input  logic [ACC_W-1:0] chain_in,
    output logic             v_out,
    output logic [ACC_W-1:0] result,
    output logic [ACC_W-1:0] acc_out
);
    logic [ACC_W-1:0] base, term, nxt;

    always_comb begin
        base = (ac.acc_clr || !ac.acc_en) ? '0 : acc_out;
        term = ac.acc_sub ? (~sum_in + ACC_W'(1)) : sum_in;
        nxt  = base + term + chain_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out   <= 1'b0;
            result  <= '0;
            acc_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                acc_out <= nxt;
                result  <= round_val(nxt, ac.round_en, ac.round_pos);
            end
        end
    end

    // R9: a rounded result has no bits set below the rounding position
    a_r9_round_low_zero: assert property (@(posedge clk) disable iff (rst)
        $past(v_in && ac.round_en && ac.round_pos != '0) |->
        (((result >> $past(ac.round_pos)) << $past(ac.round_pos)) == result));

    // R7: after an additive clear the value is product sum plus chain input only
    a_r7_clear_base: assert property (@(posedge clk) disable iff (rst)
        $past(v_in && ac.acc_clr && !ac.acc_sub) |->
        (acc_out == $past(sum_in + chain_in)));
endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                mode,
    input  logic                preadd_en,
    input  logic                prod_sub,
    input  logic                acc_en,
    input  logic                acc_sub,
    input  logic                acc_clr,
    input  logic                round_en,
    input  logic [RPOS_W-1:0]   round_pos,
    input  logic                casc_sel,
    input  logic                coef_use,
    input  logic [COEF_AW-1:0]  coef_idx,
    input  logic                coef_we,
    input  logic [COEF_AW-1:0]  coef_waddr,
    input  logic [DATA_W-1:0]   coef_wdata,
    input  logic [DATA_W-1:0]   a_in,
    input  logic [PRE_W-1:0]    y_in,
    input  logic [DATA_W-1:0]   b_in,
    input  logic [NA_W-1:0]     c_in,
    input  logic [NB_W-1:0]     d_in,
    input  logic [DATA_W-1:0]   cascade_in,
    input  logic [ACC_W-1:0]    chain_in,
    output logic [DATA_W-1:0]   cascade_out,
    output logic                out_valid,
    output logic [ACC_W-1:0]    result,
    output logic [ACC_W-1:0]    chain_out
);
    logic [DATA_W-1:0] coef_rd;
    logic              v1;
    mul_ctl_t          mc1;
    acc_ctl_t          ac1;
    logic [DATA_W-1:0] a1, b1;
    logic [PRE_W-1:0]  y1;
    logic [NA_W-1:0]   c1;
    logic [NB_W-1:0]   d1;
    logic              v2;
    logic [ACC_W-1:0]  sum2;
    acc_ctl_t          ac2;

    mac_coef_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (coef_we),
        .waddr (coef_waddr),
        .wdata (coef_wdata),
        .raddr (coef_idx),
        .rdata (coef_rd)
    );

    // input register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            v1  <= 1'b0;
            mc1 <= '0;
            ac1 <= '0;
            a1  <= '0;
            b1  <= '0;
            y1  <= '0;
            c1  <= '0;
            d1  <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                a1  <= casc_sel ? cascade_in : a_in;
                b1  <= coef_use ? coef_rd : b_in;
                y1  <= y_in;
                c1  <= c_in;
                d1  <= d_in;
                mc1 <= '{mode: mode_e'(mode), preadd: preadd_en, sub: prod_sub};
                ac1 <= '{acc_en: acc_en, acc_sub: acc_sub, acc_clr: acc_clr,
                         round_en: round_en, round_pos: round_pos};
            end
        end
    end

    assign cascade_out = a1 & casc_mask(mc1.mode, mc1.preadd);

    mac_mult_stage u_mult (
        .clk     (clk),
        .rst     (rst),
        .v_in    (v1),
        .mc      (mc1),
        .ac_in   (ac1),
        .a       (a1),
        .y       (y1),
        .b       (b1),
        .c       (c1),
        .d       (d1),
        .v_out   (v2),
        .sum_out (sum2),
        .ac_out  (ac2)
    );

    mac_acc_stage u_acc (
        .clk      (clk),
        .rst      (rst),
        .v_in     (v2),
        .sum_in   (sum2),
        .ac       (ac2),
        .chain_in (chain_in),
        .v_out    (out_valid),
        .result   (result),
        .acc_out  (chain_out)
    );

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R10: out_valid follows in_valid three edges later
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));
endmodule

// File: tb/sim_mac_slice.sv
`timescale 1ns/1ps
module sim_mac_slice;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, mode, preadd_en, prod_sub, acc_en, acc_sub, acc_clr, round_en;
    logic [5:0]  round_pos;
    logic        casc_sel, coef_use, coef_we;
    logic [2:0]  coef_idx, coef_waddr;
    logic [26:0] coef_wdata, a_in, b_in, cascade_in;
    logic [17:0] y_in, d_in;
    logic [18:0] c_in;
    logic [63:0] chain_in;
    logic [26:0] cascade_out;
    logic        out_valid;
    logic [63:0] result, chain_out;

    mac_slice u0 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    string tag = "R11";

    // ---------------- behavioural reference ----------------
    typedef struct { int due; logic [63:0] res; logic [63:0] acc; } exp_t;
    exp_t        q[$];
    int          cyc = 0;
    logic [63:0] m_acc = 0;
    logic [63:0] last_res = 0, last_acc = 0;
    logic [26:0] m_cas = 0;
    logic [26:0] coef_m [8];

    function automatic longint sx(input longint v, input int w);
        longint t;
        t = v <<< (64 - w);
        return t >>> (64 - w);
    endfunction

    function automatic logic [63:0] rnd(input logic [63:0] v, input logic en, input int k);
        logic [63:0] t;
        if (!en || k == 0) return v;
        t = v + (64'd1 << (k - 1));
        return (t >> k) << k;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cyc = 0; m_acc = 0; last_res = 0; last_acc = 0; m_cas = 0;
            for (int i = 0; i < 8; i++) coef_m[i] = 0;
        end else begin
            cyc = cyc + 1;
            if (in_valid) begin
                longint a, bb, opa, s, base, term;
                logic [63:0] nv;
                exp_t e;
                a  = casc_sel ? longint'(cascade_in) : longint'(a_in);
                bb = coef_use ? longint'(coef_m[coef_idx]) : longint'(b_in);
                if (preadd_en) opa = sx(a, 18) + sx(longint'(y_in), 18);
                else           opa = mode ? sx(a, 27) : sx(a, 19);
                if (mode) s = opa * sx(bb, 27);
                else begin
                    s = opa * sx(bb, 18);
                    if (prod_sub) s = s - sx(longint'(c_in), 19) * sx(longint'(d_in), 18);
                    else          s = s + sx(longint'(c_in), 19) * sx(longint'(d_in), 18);
                end
                base = (acc_clr || !acc_en) ? 0 : longint'(m_acc);
                term = acc_sub ? -s : s;
                nv = 64'(base + term) + chain_in;
                m_acc = nv;
                e.due = cyc + 2; e.acc = nv; e.res = rnd(nv, round_en, int'(round_pos));
                q.push_back(e);
                if (preadd_en)  m_cas = 27'(a) & 27'h003ffff;
                else if (!mode) m_cas = 27'(a) & 27'h007ffff;
                else            m_cas = 27'(a);
            end
            if (coef_we) coef_m[coef_waddr] = coef_wdata;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic ev;
            ev = 1'b0;
            if (q.size() > 0 && q[0].due == cyc) begin
                ev = 1'b1; last_res = q[0].res; last_acc = q[0].acc;
                void'(q.pop_front());
            end
            chk("out_valid", 64'(out_valid), 64'(ev));
            chk("result", result, last_res);
            chk("chain_out", chain_out, last_acc);
            chk("cascade_out", 64'(cascade_out), 64'(m_cas));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic md, input logic pre, input logic sb,
                        input logic [26:0] a, input logic [17:0] y, input logic [26:0] b,
                        input logic [18:0] c, input logic [17:0] d);
        in_valid = 1'b1; mode = md; preadd_en = pre; prod_sub = sb;
        a_in = a; y_in = y; b_in = b; c_in = c; d_in = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wcoef(input logic [2:0] ad, input logic [26:0] v);
        coef_we = 1'b1; coef_waddr = ad; coef_wdata = v;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    initial begin
        logic [31:0] seed;
        rst = 1'b1;
        in_valid = 0; mode = 0; preadd_en = 0; prod_sub = 0; acc_en = 0; acc_sub = 0;
        acc_clr = 0; round_en = 0; round_pos = 0; casc_sel = 0; coef_use = 0;
        coef_idx = 0; coef_we = 0; coef_waddr = 0; coef_wdata = 0; a_in = 0; b_in = 0;
        y_in = 0; c_in = 0; d_in = 0; cascade_in = 0; chain_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R11"; idle(3);

        tag = "R1";
        send(0, 0, 0, 27'd5, 0, 27'd3, 19'd7, 18'd2);
        send(0, 0, 0, 27'h7f40000, 0, 27'h7fe0000, 19'h40000, 18'h20000);
        send(0, 0, 1, 27'd1000, 0, 27'h3ffff, 19'h7ffff, 18'd9);
        send(0, 0, 1, 27'h3ffff, 0, 27'h1ffff, 19'h40000, 18'h1ffff);
        idle(3);

        tag = "R2";
        send(1, 0, 0, 27'h4000000, 0, 27'h4000000, 19'h12345, 18'h3ffff);
        send(1, 0, 1, 27'h3ffffff, 0, 27'h4000000, 19'h7ffff, 18'd1);
        send(1, 0, 0, 27'd12345, 0, 27'h7fffff9, 0, 0);
        idle(3);

        tag = "R3";
        send(0, 1, 0, 27'h7f1ffff, 18'h1ffff, 27'h20000, 19'd3, 18'd4);
        send(0, 1, 1, 27'h20000, 18'h20000, 27'h1ffff, 19'd2, 18'h3ffff);
        send(1, 1, 0, 27'h5555555, 18'h2aaaa, 27'h4000001, 0, 0);
        idle(3);

        tag = "R4";
        casc_sel = 1; cascade_in = 27'h7ffffff;
        send(0, 0, 0, 27'd1, 0, 27'd2, 0, 0);
        send(0, 1, 0, 27'd1, 18'd3, 27'd2, 0, 0);
        cascade_in = 27'h5a5a5a5;
        send(1, 0, 0, 27'd1, 0, 27'h7ffffff, 0, 0);
        idle(2);
        casc_sel = 0;
        idle(2);

        tag = "R5";
        for (int i = 0; i < 8; i++) wcoef(3'(i), 27'(i * 1001 + 27'h4000000 * (i % 2)));
        coef_use = 1; coef_idx = 3;
        send(0, 0, 0, 27'd77, 0, 27'd5, 0, 0);
        coef_idx = 7;
        send(1, 0, 0, 27'h7ffff00, 0, 27'd5, 0, 0);
        coef_idx = 2; coef_we = 1; coef_waddr = 2; coef_wdata = 27'd999;
        send(0, 0, 0, 27'd11, 0, 0, 0, 0);
        coef_we = 0;
        send(0, 0, 0, 27'd11, 0, 0, 0, 0);
        coef_use = 0;
        idle(3);

        tag = "R6";
        acc_en = 1; acc_clr = 1;
        send(0, 0, 0, 27'd100, 0, 27'd3, 19'd1, 18'd1);
        acc_clr = 0;
        send(0, 0, 0, 27'd50, 0, 27'd2, 0, 0);
        idle(2);
        send(1, 0, 0, 27'd1000, 0, 27'd1000, 0, 0);
        acc_sub = 1;
        send(0, 0, 0, 27'd7, 0, 27'd7, 0, 0);
        send(1, 0, 0, 27'h4000000, 0, 27'd1, 0, 0);
        acc_sub = 0;
        idle(3);

        tag = "R7";
        acc_clr = 1;
        send(0, 0, 0, 27'd9, 0, 27'd9, 0, 0);
        acc_clr = 0;
        send(0, 0, 0, 27'd1, 0, 27'd1, 0, 0);
        acc_clr = 1; acc_sub = 1;
        send(0, 0, 0, 27'd4, 0, 27'd4, 0, 0);
        acc_clr = 0; acc_sub = 0;
        idle(3);

        tag = "R8";
        chain_in = 64'h1000_0000_0000_0001;
        idle(3);
        acc_en = 0;
        send(0, 0, 0, 27'd3, 0, 27'd3, 0, 0);
        acc_en = 1;
        send(0, 0, 0, 27'd3, 0, 27'd3, 0, 0);
        send(0, 0, 0, 27'd3, 0, 27'd3, 0, 0);
        idle(3);
        chain_in = 64'hffff_ffff_ffff_ffff;
        idle(3);
        acc_en = 0;
        send(1, 0, 0, 27'd1, 0, 27'd1, 0, 0);
        idle(3);
        chain_in = 0;
        idle(3);

        tag = "R9";
        round_en = 1; acc_en = 0;
        round_pos = 0;  send(0, 0, 0, 27'd1023, 0, 27'd1, 0, 0);
        round_pos = 1;  send(0, 0, 0, 27'd3, 0, 27'd1, 0, 0);
        round_pos = 4;  send(0, 0, 0, 27'h7ffffff, 0, 27'd8, 0, 0);
        round_pos = 20; send(1, 0, 0, 27'h3ffffff, 0, 27'h7ffffff, 0, 0);
        round_pos = 63; send(1, 0, 0, 27'h4000000, 0, 27'h4000000, 0, 0);
        round_pos = 5;  round_en = 0; send(0, 0, 0, 27'd31, 0, 27'd1, 0, 0);
        idle(3);

        tag = "R10";
        seed = 32'h1234_5678;
        for (int i = 0; i < 200; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            acc_en = seed[0]; acc_sub = seed[1]; acc_clr = seed[2] & seed[3];
            round_en = seed[4]; round_pos = seed[10:5];
            coef_use = seed[11]; coef_idx = seed[14:12]; casc_sel = seed[15];
            cascade_in = {seed[26:0]};
            if (seed[16]) begin
                send(seed[17], seed[18], seed[19], {seed[31:5]}, {seed[17:0]},
                     {seed[26:0] ^ 27'h2aaaaaa}, {seed[18:0]}, {seed[30:13]});
            end else begin
                idle(1);
            end
        end
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog %s run did not finish", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule